// File: doc/BRIEF.md
# Block transfer address sequencer

This block generates the memory access sequence for a multiple-register load or store. A request gives a byte base address, a register list (bit n set means register n takes part), a direction bit, a before/after bit, a write-back bit, a load/store bit and the index of the base register. One cycle after a start pulse is accepted, the block issues one access per cycle until the list is exhausted. Each access carries a word-aligned byte address, the register index and a write strobe. A done pulse accompanies the last access, and the updated base value is presented in that same cycle.

Registers are always visited in ascending index order at ascending addresses, whatever the mode. Only the start address and the final base value depend on the direction and before/after bits. The four stack disciplines map onto these modes. Full-descending pushes with decrement-before and pops with increment-after. Empty-ascending pushes with increment-after and pops with decrement-before. Full-ascending uses increment-before and decrement-after. Empty-descending uses decrement-after and increment-before. An empty list is illegal; it is reported as an error and produces no access.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, busy, acc_valid, done, err and wb_en are all 0.
- R2: For an accepted request with N set list bits (N from 1 to 16), exactly N accesses follow in the N consecutive cycles after the accepting edge. acc_reg gives the set bit positions in ascending order.
- R3: The base is used with bits [1:0] forced to 0; call it B. The first access address is B when up_dir=1 and pre_idx=0, B+4 when up_dir=1 and pre_idx=1, B-4N+4 when up_dir=0 and pre_idx=0, and B-4N when up_dir=0 and pre_idx=1. Each later access adds 4, with modulo 2^32 wrap.
- R4: acc_write is 1 on every access of a store (is_load=0) and 0 on every access of a load.
- R5: done is high for exactly one cycle, the cycle of the last access. busy is high from the first cycle after acceptance through the done cycle.
- R6: When wr_back=1, wb_en pulses with done and wb_value is B+4N if up_dir=1, or B-4N if up_dir=0. When wr_back=0, wb_en stays 0.
- R7: For a load whose list includes bit base_reg, wb_en stays 0, because the loaded data must win over the updated address.
- R8: An empty list raises err and done together for one cycle, one cycle after acceptance. No access and no wb_en occur.
- R9: start is accepted only while busy is 0. A start while busy is ignored and the request inputs may change without effect on the running sequence.
- R10: A full-descending push followed by a pop of the same list, using the written-back base, touches the same addresses and restores the original base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken when idle |
| base_addr | input | AW | Byte base address |
| reg_list | input | NREG | Register selection mask |
| pre_idx | input | 1 | 1: offset before access, 0: after |
| up_dir | input | 1 | 1: increment, 0: decrement |
| wr_back | input | 1 | Request base write-back |
| is_load | input | 1 | 1: load, 0: store |
| base_reg | input | IW | Index of the base register |
| busy | output | 1 | Sequence in progress |
| acc_valid | output | 1 | Access issued this cycle |
| acc_addr | output | AW | Access byte address, word aligned |
| acc_reg | output | IW | Register index of the access |
| acc_write | output | 1 | Access writes memory |
| done | output | 1 | Sequence ends this cycle |
| err | output | 1 | Empty list rejected |
| wb_en | output | 1 | Base write-back enable |
| wb_value | output | AW | Updated base value |

## Verification
The assertions assume a sequence only changes through the block's own acceptance rule. They also assume that reg_list and base_reg are captured at the accepting edge, so step and ordering properties look only at the registered outputs between start and done. The stimulus respects this by holding start for exactly one cycle in most runs and for whole sequences in the busy-start runs. In those runs the request inputs change while the sequence runs, which checks that nothing latched is disturbed. Lists cover single bits at both ends, all sixteen bits, sparse patterns and the empty case. Bases cover unaligned values and values near zero and the top of the address space, so that the modular wrap is exercised.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int AW = 32,
  parameter int NREG = 16,
  localparam int IW = $clog2(NREG),
  localparam int CW = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [NREG-1:0] reg_list,
  input  logic          pre_idx,
  input  logic          up_dir,
  input  logic          wr_back,
  input  logic          is_load,
  input  logic [IW-1:0] base_reg,
  output logic          busy,
  output logic          acc_valid,
  output logic [AW-1:0] acc_addr,
  output logic [IW-1:0] acc_reg,
  output logic          acc_write,
  output logic          done,
  output logic          err,
  output logic          wb_en,
  output logic [AW-1:0] wb_value
);

  logic            run_q, err_q, load_q, wb_ok_q;
  logic [NREG-1:0] mask_q;
  logic [AW-1:0]   addr_q, wbv_q;

  logic [CW-1:0]   cnt;
  logic [AW-1:0]   span, base_al, first_addr, next_base;
  logic [IW-1:0]   pick;
  logic            last, take;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) cnt = cnt + CW'(reg_list[i]);
  end

  always_comb begin
    pick = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (mask_q[i]) pick = IW'(i);
  end

  assign span      = {{(AW-CW){1'b0}}, cnt} << 2;
  assign base_al   = {base_addr[AW-1:2], 2'b00};
  assign next_base = up_dir ? base_al + span : base_al - span;
  assign first_addr = up_dir ? (pre_idx ? base_al + AW'(4) : base_al)
                             : (pre_idx ? base_al - span : base_al - span + AW'(4));
  assign last = (mask_q & (mask_q - NREG'(1))) == '0;
  assign take = start && !run_q && !err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      err_q   <= 1'b0;
      load_q  <= 1'b0;
      wb_ok_q <= 1'b0;
      mask_q  <= '0;
      addr_q  <= '0;
      wbv_q   <= '0;
    end else if (take) begin
      run_q   <= cnt != '0;
      err_q   <= cnt == '0;
      load_q  <= is_load;
      wb_ok_q <= wr_back && !(is_load && reg_list[base_reg]);
      mask_q  <= reg_list;
      addr_q  <= first_addr;
      wbv_q   <= next_base;
    end else begin
      err_q <= 1'b0;
      if (run_q) begin
        mask_q <= mask_q & ~(NREG'(1) << pick);
        addr_q <= addr_q + AW'(4);
        if (last) run_q <= 1'b0;
      end
    end
  end

  assign busy      = run_q | err_q;
  assign acc_valid = run_q;
  assign acc_addr  = addr_q;
  assign acc_reg   = pick;
  assign acc_write = run_q && !load_q;
  assign done      = (run_q && last) || err_q;
  assign err       = err_q;
  assign wb_en     = run_q && last && wb_ok_q;
  assign wb_value  = wbv_q;

  // R3
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> acc_addr[1:0] == 2'b00);

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !done) |=> (acc_valid && acc_addr == $past(acc_addr) + AW'(4)));

  // R2
  reg_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !done) |=> (acc_reg > $past(acc_reg)));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R6
  wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done && acc_valid);

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && !acc_valid && !wb_en);

  // R9
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);

  // R4
  store_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_write |-> acc_valid);

endmodule

// File: tb/blk_xfer_seq_test.sv
module blk_xfer_seq_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [15:0] reg_list = '0;
  logic pre_idx = 0, up_dir = 0, wr_back = 0, is_load = 0;
  logic [3:0] base_reg = '0;
  logic busy, acc_valid, acc_write, done, err, wb_en;
  logic [31:0] acc_addr, wb_value;
  logic [3:0] acc_reg;
  int total = 0, bad = 0;

  typedef struct packed {
    logic [31:0] a; logic [3:0] r; logic w; logic d; logic e; logic we; logic [31:0] wv;
  } exp_t;
  exp_t q[$];
  logic [31:0] seen_first, seen_wb;
  bit capture_first;

  always #4 clk = ~clk;

  blk_xfer_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .reg_list(reg_list),
    .pre_idx(pre_idx), .up_dir(up_dir), .wr_back(wr_back), .is_load(is_load),
    .base_reg(base_reg), .busy(busy), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_reg(acc_reg), .acc_write(acc_write), .done(done), .err(err), .wb_en(wb_en),
    .wb_value(wb_value)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_push();
    int n = 0, k = 0;
    logic [31:0] b, lo, wv;
    exp_t e;
    for (int i = 0; i < 16; i++) if (reg_list[i]) n++;
    b = base_addr & ~32'd3;
    if (n == 0) begin
      e = '0; e.d = 1; e.e = 1;
      q.push_back(e);
      return;
    end
    if (up_dir) lo = pre_idx ? b + 4 : b;
    else        lo = pre_idx ? b - 32'(4*n) : b - 32'(4*n) + 4;
    wv = up_dir ? b + 32'(4*n) : b - 32'(4*n);
    for (int i = 0; i < 16; i++) begin
      if (reg_list[i]) begin
        e = '0;
        e.a = lo + 32'(4*k); e.r = 4'(i); e.w = !is_load; e.d = (k == n-1);
        e.we = e.d && wr_back && !(is_load && reg_list[base_reg]);
        e.wv = wv;
        q.push_back(e);
        k++;
      end
    end
  endtask

  task automatic step(input bit s);
    exp_t e;
    bit have, acc;
    @(negedge clk);
    have = q.size() > 0;
    e = have ? q[0] : '0;
    chk(busy == have, "R5 busy", 32'(busy), 32'(have));
    chk(acc_valid == (have && !e.e), "R2 acc_valid", 32'(acc_valid), 32'(have && !e.e));
    if (have && !e.e && acc_valid) begin
      chk(acc_addr == e.a, "R3 acc_addr", acc_addr, e.a);
      chk(acc_reg == e.r, "R2 acc_reg", 32'(acc_reg), 32'(e.r));
      chk(acc_write == e.w, "R4 acc_write", 32'(acc_write), 32'(e.w));
      if (capture_first) begin seen_first = acc_addr; capture_first = 0; end
    end
    chk(done == e.d, "R5 done", 32'(done), 32'(e.d));
    chk(err == e.e, "R8 err", 32'(err), 32'(e.e));
    chk(wb_en == e.we, "R6 wb_en", 32'(wb_en), 32'(e.we));
    if (e.we && wb_en) begin
      chk(wb_value == e.wv, "R6 wb_value", wb_value, e.wv);
      seen_wb = wb_value;
    end
    acc = s && !have;
    if (have) void'(q.pop_front());
    if (acc) model_push();
    start = s;
  endtask

  task automatic run(input logic [31:0] b, input logic [15:0] l, input bit p, input bit u,
                     input bit w, input bit ld, input logic [3:0] bi, input bit hold);
    base_addr = b; reg_list = l; pre_idx = p; up_dir = u; wr_back = w; is_load = ld; base_reg = bi;
    capture_first = 1;
    step(1);
    step(hold);
    // R9: scramble request inputs while busy
    base_addr = ~b; reg_list = ~l; pre_idx = !p; up_dir = !u;
    while (q.size() > 0) step(hold);
    step(0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R5 watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] sp0, push_first, push_wb;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && acc_valid == 0 && done == 0 && err == 0 && wb_en == 0, "R1 reset idle",
        {27'd0, busy, acc_valid, done, err, wb_en}, 32'd0);
    rst_n = 1;
    step(0);
    // R2 R3 R4 R6: each mode, store and load
    for (int m = 0; m < 4; m++) begin
      run(32'h0000_1000, 16'h803B, m[0], m[1], 1, 0, 4'd13, 0);
      run(32'h0000_2003, 16'h0421, m[0], m[1], 1, 1, 4'd13, 0);
      run(32'h0000_3000, 16'h0001, m[0], m[1], 0, 1, 4'd0, 0);
      run(32'h0000_4000, 16'h8000, m[0], m[1], 1, 0, 4'd15, 0);
      run(32'h0000_5000, 16'hFFFF, m[0], m[1], 1, 0, 4'd2, 0);
    end
    // R3 wrap near zero and top
    run(32'h0000_0008, 16'h00FF, 1, 0, 1, 0, 4'd9, 0);
    run(32'hFFFF_FFF0, 16'h0F0F, 1, 1, 1, 1, 4'd14, 0);
    // R7 load with base in list: no write-back; store with base in list still writes back
    run(32'h0000_6000, 16'h2006, 0, 1, 1, 1, 4'd13, 0);
    run(32'h0000_6000, 16'h2006, 0, 1, 1, 0, 4'd13, 0);
    // R8 empty list
    run(32'h0000_7000, 16'h0000, 1, 0, 1, 1, 4'd0, 0);
    run(32'h0000_7000, 16'h0000, 0, 1, 0, 0, 4'd0, 1);
    // R9 start held through whole sequences
    run(32'h0000_8000, 16'h1111, 1, 1, 1, 0, 4'd3, 1);
    run(32'h0000_8800, 16'hC003, 0, 0, 1, 1, 4'd5, 1);
    // R10 full-descending push then pop
    sp0 = 32'h0001_0000;
    run(sp0, 16'h400F, 1, 0, 1, 0, 4'd13, 0);
    push_first = seen_first; push_wb = seen_wb;
    run(push_wb, 16'h400F, 0, 1, 1, 1, 4'd13, 0);
    chk(seen_first == push_first, "R10 pop address", seen_first, push_first);
    chk(seen_wb == sp0, "R10 restored base", seen_wb, sp0);
    // random mix
    for (int t = 0; t < 300; t++) begin
      logic [31:0] r;
      r = $urandom;
      run($urandom, 16'($urandom) & (r[20] ? 16'hFFFF : 16'h0F0F & 16'(r)), r[0], r[1], r[2], r[3],
          r[7:4], r[8] && r[9]);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule